// File: doc/BRIEF.md
# I2C Register-Write Slave Front End

This block sits behind the two pins of an I2C bus and turns write transfers from a bus master into register writes inside the chip. It samples SCL and SDA with the system clock, which must run at least eight times faster than the bus bit rate. It finds START and STOP conditions and reads the first byte of each transfer as a 7-bit device address plus a direction bit. The least significant address bit comes from a strap input, so two copies of the block can share one bus.

After an address match the block acknowledges. In a write transfer, the next byte is loaded as an internal register pointer. Every byte after that is acknowledged and presented as a one-cycle write strobe, together with the pointer and the data. The pointer then steps by one, so a single transfer can fill a run of registers from any starting point until the master sends STOP. A matched read transfer is acknowledged and flagged on a level output. The block returns no read data.

The SDA pin is never driven high. The block only asserts a pull-down enable, which the pad turns into an open-drain low.

Top module: `i2c_regwr_slave`

## Requirements
- R1: SDA falling while SCL is high is a START, and it begins address reception from any state. SDA rising while SCL is high is a STOP, which returns the block to idle with `sda_pull` and `rd_mode` low.
- R2: The first byte after START is received MSB first. It matches when its upper seven bits equal 7'h1A with bit 0 replaced by `addr_sel`. As a whole write byte this is 0x34 for `addr_sel`=0 and 0x36 for `addr_sel`=1. Bit 0 of the byte is the direction: 1 means read, 0 means write.
- R3: An acknowledge is given by raising `sda_pull` after the SCL fall that ends the 8th bit and dropping it after the SCL fall that ends the 9th bit. `sda_pull` is never raised while SCL is high.
- R4: After a non-matching address byte, no acknowledge is given, no write strobe occurs and `rd_mode` stays low for every later byte, until the next START.
- R5: In a matched write, the second byte is acknowledged and loaded as the register pointer.
- R6: Each later byte is acknowledged and produces exactly one `wr_en` pulse of one cycle, with `reg_addr` equal to the pointer and `wr_data` equal to the byte. The pulse is valid no more than 8 system cycles after the 8th SCL rise of the byte.
- R7: The pointer increases by one after each data byte, wrapping from 0xFF to 0x00.
- R8: A matched read address is acknowledged and raises `rd_mode` until the next START or STOP. No write strobe occurs while `rd_mode` is high.
- R9: A repeated START in the middle of a write transfer, with no STOP before it, restarts address reception. The following bytes are handled as a new transfer.
- R10: After reset, `sda_pull`, `wr_en` and `rd_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL pin level, asynchronous |
| sda_i | input | 1 | SDA pin level, asynchronous |
| addr_sel | input | 1 | Strap that supplies the device address LSB |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Register address of the current write strobe |
| wr_data | output | 8 | Data of the current write strobe |
| wr_en | output | 1 | One-cycle write strobe |
| rd_mode | output | 1 | A matched read transfer is active |

## Verification
Directed transfers cover each strap value against both matching and non-matching address bytes, which separates the address compare from the strap path. They also cover a read-direction address, which shows the direction bit is honoured. A write that starts at 0xFE shows the pointer wrap. A repeated START between two writes, with no STOP, shows that the register byte of the second transfer reloads the pointer. Seeded random transfers then mix strap values, matching and foreign addresses, start registers, lengths of one to five bytes and data values. Each one is compared against a bench model of the expected acknowledges and of the ordered address and data pairs, so a missing, extra or shifted write shows up as a mismatch.

// File: rtl/i2c_regwr_pkg.sv
// Package: shared types of the I2C register-write slave.
// Assumes: 8-bit bytes on the bus and an 8-bit register space.
package i2c_regwr_pkg;
    localparam int unsigned BYTE_W = 8;

    // Transfer phase of the slave controller
    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for START
        PH_DEVID,   // shifting in the device address byte
        PH_REGPTR,  // shifting in the register pointer byte
        PH_WDATA,   // shifting in a data byte
        PH_ACKBIT,  // driving the acknowledge bit
        PH_RDHOLD,  // matched read, holding until START/STOP
        PH_SKIP     // not addressed, ignoring until START
    } xfer_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings one asynchronous bus line into the clk domain through a
// flop chain and reports single-cycle rise and fall events.
// Assumes: an idle bus line is high, so every flop resets to 1.
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: capture the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_i;
            end
        end else begin : g_chain
            // Multi stage: shift the raw line through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[TOP];
    end

    assign level_o = chain_q[TOP];
    assign rise_o  = chain_q[TOP] & ~last_q;
    assign fall_o  = ~chain_q[TOP] & last_q;
endmodule

// File: rtl/i2c_bus_cond.sv
// Module: i2c_bus_cond
// Decodes START and STOP from synchronized SCL level and SDA edges.
// Assumes: SDA only moves while SCL is low during data bits, so an
// SDA edge seen while SCL is high is a bus condition.
module i2c_bus_cond (
    input  logic scl_level,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // Classify SDA edges that happen while SCL is high
    always_comb begin
        start_o = scl_level & sda_fall;
        stop_o  = scl_level & sda_rise;
    end
endmodule

// File: rtl/i2c_byte_rx.sv
// Module: i2c_byte_rx
// Shifts bus bits in MSB first and flags the 8th bit, presenting the
// full byte (including that 8th bit) in the same cycle.
// Assumes: sample_i is a single-cycle SCL-rise event.
module i2c_byte_rx #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            sample_i,
    input  logic            bit_i,
    output logic [BITS-1:0] byte_o,
    output logic            done_o
);
    localparam int unsigned CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic [BITS-1:0]  shift_q;
    logic [CNT_W-1:0] count_q;

    // Shift register and bit counter; the counter wraps after each byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            shift_q <= '0;
            count_q <= '0;
        end else if (sample_i) begin
            shift_q <= {shift_q[BITS-2:0], bit_i};
            count_q <= (count_q == LAST) ? '0 : count_q + 1'b1;
        end
    end

    assign byte_o = {shift_q[BITS-2:0], bit_i};
    assign done_o = sample_i && (count_q == LAST);
endmodule

// File: rtl/i2c_xfer_fsm.sv
// Module: i2c_xfer_fsm
// Transfer controller: address compare, acknowledge timing, register
// pointer load and auto-increment, and the write strobe.
// Assumes: start/stop/scl_fall are single-cycle events in clk domain.
module i2c_xfer_fsm
    import i2c_regwr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter logic [5:0]  DEV_HI  = 6'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_fall_i,
    input  logic              strap_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              rx_active_o,
    output logic              ack_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_en_o,
    output logic              rd_mode_o,
    output logic [ADDR_W-1:0] ptr_o
);
    xfer_phase_e      phase_q;
    xfer_phase_e      after_ack_q;
    logic             ack_q;
    logic             rd_q;
    logic             wr_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] reg_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic [6:0]        dev_id;

    // Own 7-bit device address with the strap as LSB
    assign dev_id = {DEV_HI, strap_i};

    // Main phase machine with write strobe and pointer handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            after_ack_q <= PH_IDLE;
            ack_q       <= 1'b0;
            rd_q        <= 1'b0;
            wr_q        <= 1'b0;
            ptr_q       <= '0;
            reg_addr_q  <= '0;
            wr_data_q   <= '0;
        end else begin
            wr_q <= 1'b0;
            if (start_i) begin
                phase_q <= PH_DEVID;
                ack_q   <= 1'b0;
                rd_q    <= 1'b0;
            end else if (stop_i) begin
                phase_q <= PH_IDLE;
                ack_q   <= 1'b0;
                rd_q    <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_DEVID: if (byte_done_i) begin
                        if (byte_i[7:1] == dev_id) begin
                            phase_q     <= PH_ACKBIT;
                            after_ack_q <= byte_i[0] ? PH_RDHOLD : PH_REGPTR;
                            rd_q        <= byte_i[0];
                        end else begin
                            phase_q <= PH_SKIP;
                        end
                    end
                    PH_REGPTR: if (byte_done_i) begin
                        ptr_q       <= ADDR_W'(byte_i);
                        phase_q     <= PH_ACKBIT;
                        after_ack_q <= PH_WDATA;
                    end
                    PH_WDATA: if (byte_done_i) begin
                        reg_addr_q  <= ptr_q;
                        wr_data_q   <= byte_i;
                        wr_q        <= 1'b1;
                        ptr_q       <= ptr_q + 1'b1;
                        phase_q     <= PH_ACKBIT;
                        after_ack_q <= PH_WDATA;
                    end
                    PH_ACKBIT: if (scl_fall_i) begin
                        if (!ack_q) begin
                            ack_q <= 1'b1;
                        end else begin
                            ack_q   <= 1'b0;
                            phase_q <= after_ack_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rx_active_o = (phase_q == PH_DEVID) || (phase_q == PH_REGPTR) ||
                         (phase_q == PH_WDATA);
    assign ack_o       = ack_q;
    assign reg_addr_o  = reg_addr_q;
    assign wr_data_o   = wr_data_q;
    assign wr_en_o     = wr_q;
    assign rd_mode_o   = rd_q;
    assign ptr_o       = ptr_q;
endmodule

// File: rtl/i2c_regwr_slave.sv
// Module: i2c_regwr_slave (top)
// I2C slave that acknowledges its strapped address and turns write
// transfers into auto-incrementing register write strobes.
// Assumes: clk is at least 8x the SCL rate; sda_pull feeds an
// open-drain pad, so SDA is only ever pulled low.
module i2c_regwr_slave #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [5:0]  DEV_HI      = 6'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        wr_data,
    output logic              wr_en,
    output logic              rd_mode
);
    import i2c_regwr_pkg::*;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;
    logic rx_active, byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [ADDR_W-1:0] wr_ptr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2c_bus_cond u_cond (
        .scl_level(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    i2c_byte_rx #(.BITS(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear_i(start_det),
        .sample_i(scl_rise & rx_active), .bit_i(sda_lvl),
        .byte_o(rx_byte), .done_o(byte_done)
    );

    i2c_xfer_fsm #(.ADDR_W(ADDR_W), .DEV_HI(DEV_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_det), .stop_i(stop_det), .scl_fall_i(scl_fall),
        .strap_i(addr_sel), .byte_done_i(byte_done), .byte_i(rx_byte),
        .rx_active_o(rx_active), .ack_o(sda_pull),
        .reg_addr_o(reg_addr), .wr_data_o(wr_data), .wr_en_o(wr_en),
        .rd_mode_o(rd_mode), .ptr_o(wr_ptr)
    );
endmodule

// Checker: temporal properties of the slave, attached by bind below.
module i2c_regwr_slave_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_pull,
    input logic              wr_en,
    input logic              rd_mode,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [ADDR_W-1:0] wr_ptr
);
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_pull && !rd_mode));

    assert_ack_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_ptr == reg_addr + 1'b1));

    assert_no_write_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> !wr_en);

    assert_restart_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull);
endmodule

bind i2c_regwr_slave i2c_regwr_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
    .stop_det(stop_det), .sda_pull(sda_pull), .wr_en(wr_en),
    .rd_mode(rd_mode), .reg_addr(reg_addr), .wr_ptr(wr_ptr)
);

// File: tb/tb_i2c_regwr_slave.sv
// Bench: drives an open-drain I2C bus model against the slave and
// compares acknowledges and captured writes with a bench model.
module tb_i2c_regwr_slave;
    localparam int Q = 6;   // quarter bit period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_line;
    logic       sda_pull;
    logic [7:0] reg_addr;
    logic [7:0] wr_data;
    logic       wr_en;
    logic       rd_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] cap_a [0:255];
    logic [7:0] cap_d [0:255];
    int         cap_n = 0;

    logic [7:0] exp_a [0:255];
    logic [7:0] exp_d [0:255];
    int         exp_n = 0;

    logic [7:0] tx_d [0:15];

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = sda_m & ~sda_pull;

    i2c_regwr_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(strap), .sda_pull(sda_pull), .reg_addr(reg_addr),
        .wr_data(wr_data), .wr_en(wr_en), .rd_mode(rd_mode)
    );

    // Record every cycle with a write strobe (a 2-cycle pulse records twice)
    always @(negedge clk) begin
        if (wr_en) begin
            cap_a[cap_n[7:0]] = reg_addr;
            cap_d[cap_n[7:0]] = wr_data;
            cap_n = cap_n + 1;
        end
    end

    function automatic bit addr_hits(input logic [7:0] b, input logic s);
        return b[7:1] == {6'h0D, s};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // One transfer: address byte, optional register byte and n data bytes
    task automatic transfer(input logic [7:0] abyte, input logic [7:0] reg0,
                            input int n, input bit finish, input string tag);
        bit ack;
        bit hit;
        logic [7:0] p;
        hit = addr_hits(abyte, strap);
        bus_start();
        send_byte(abyte, ack);
        chk(ack == hit, {tag, " R2 address ack"}, ack, hit);
        chk(sda_pull == 1'b0, {tag, " R3 release after ack"}, sda_pull, 0);
        if (abyte[0] && hit) begin
            chk(rd_mode == 1'b1, {tag, " R8 read flag"}, rd_mode, 1);
        end else begin
            send_byte(reg0, ack);
            chk(ack == hit, {tag, hit ? " R5 register ack" : " R4 no ack"}, ack, hit);
            p = reg0;
            for (int k = 0; k < n; k++) begin
                send_byte(tx_d[k], ack);
                chk(ack == hit, {tag, hit ? " R6 data ack" : " R4 no ack"}, ack, hit);
                chk(rd_mode == 1'b0, {tag, " R4 R8 no read flag"}, rd_mode, 0);
                if (hit) begin
                    exp_a[exp_n[7:0]] = p;
                    exp_d[exp_n[7:0]] = tx_d[k];
                    exp_n++;
                    p = p + 8'd1;
                end
            end
        end
        if (finish) begin
            bus_stop();
            chk(sda_pull == 1'b0 && rd_mode == 1'b0, {tag, " R1 idle after stop"},
                {sda_pull, rd_mode}, 0);
        end
    endtask

    // Compare all captured writes with the expected list, then clear both
    task automatic compare_writes(input string tag);
        chk(cap_n == exp_n, {tag, " R6 write count"}, cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            chk(cap_a[k] == exp_a[k], {tag, " R7 write address"}, cap_a[k], exp_a[k]);
            chk(cap_d[k] == exp_d[k], {tag, " R6 write data"}, cap_d[k], exp_d[k]);
        end
        cap_n = 0;
        exp_n = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(sda_pull == 0 && wr_en == 0 && rd_mode == 0, "R10 reset outputs",
            {sda_pull, wr_en, rd_mode}, 0);

        // Strap 0 matches 0x34, single byte write
        strap = 1'b0;
        tx_d[0] = 8'hA5;
        transfer(8'h34, 8'h12, 1, 1, "strap0");
        compare_writes("strap0");

        // Strap 0 with the strap-1 address: ignored
        tx_d[0] = 8'h11; tx_d[1] = 8'h22;
        transfer(8'h36, 8'h40, 2, 1, "foreign");
        compare_writes("R4 foreign");

        // Strap 1 matches 0x36, and 0x34 is now ignored
        strap = 1'b1;
        tx_d[0] = 8'h3C; tx_d[1] = 8'hC3;
        transfer(8'h36, 8'h20, 2, 1, "strap1");
        transfer(8'h34, 8'h20, 2, 1, "strap1 miss");
        compare_writes("strap1");

        // Pointer wrap from 0xFE
        strap = 1'b0;
        tx_d[0] = 8'h01; tx_d[1] = 8'h02; tx_d[2] = 8'h03; tx_d[3] = 8'h04;
        transfer(8'h34, 8'hFE, 4, 1, "R7 wrap");
        compare_writes("R7 wrap");

        // Read direction: acknowledged, flagged, no writes
        transfer(8'h35, 8'h00, 0, 1, "R8 read");
        compare_writes("R8 read");

        // Repeated START between two writes, no STOP in between
        tx_d[0] = 8'h5A;
        transfer(8'h34, 8'h10, 1, 0, "R9 first");
        tx_d[0] = 8'hB1; tx_d[1] = 8'hB2;
        transfer(8'h34, 8'h80, 2, 1, "R9 second");
        compare_writes("R9 restart");

        // Seeded random transfers
        void'($urandom(32'd1234));
        for (int t = 0; t < 24; t++) begin
            logic [7:0] ab;
            int n;
            strap = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: ab = 8'h34;
                1: ab = 8'h36;
                2: ab = 8'($urandom) & 8'hFE;
                default: ab = {6'h0D, strap, 1'b0};
            endcase
            n = $urandom_range(1, 5);
            for (int k = 0; k < n; k++) tx_d[k] = 8'($urandom);
            transfer(ab, 8'($urandom), n, 1, "random");
        end
        compare_writes("random");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule